// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block handles the upkeep that keeps an asynchronous DRAM alive. The DRAM has a 10-bit row address. After reset the scheduler waits out a power-up pause. It then runs a fixed burst of wake-up refresh cycles and raises `init_done` once the memory may be used. From then on it owes one refresh per interval and pays each debt by running a single refresh cycle on the strobes. Every refresh cycle first wins the memory bus from an external arbiter through a `req`/`gnt` handshake. All times are parameters counted in system clock cycles, each one rounded up from the nanosecond figure.

Two refresh styles are supported, chosen per cycle by `cbr_mode` at the moment of grant. In the CAS-first style, CAS is pulled low before RAS falls. The memory's own counter picks the row, and the address pins are left undriven. In the row-addressed style, CAS stays high and a local row counter is put on the address pins. That counter steps once per such cycle and wraps around at the top.

Refresh debts that build up while the grant is withheld are kept in a backlog counter and paid back to back. If the backlog would go past its limit, rows may have lost their contents. The block then sets a sticky error, drops `init_done`, discards the backlog and repeats the whole wake-up burst.

Top module: `dram_refresh_sched`

States: `ST_PAUSE` (power-up wait), `ST_IDLE` (no bus), `ST_REQ` (bus requested, waiting for grant), `ST_SETUP` (CAS low ahead of RAS, CAS-first only), `ST_ACT` (RAS low), `ST_PRE` (precharge). Transitions:
- pause_done: `ST_PAUSE`→`ST_IDLE` after `PAUSE_CYC` cycles.
- work_due: `ST_IDLE`→`ST_REQ` when wake-up cycles or backlog remain.
- grant_cbr: `ST_REQ`→`ST_SETUP` on grant with `cbr_mode`=1.
- grant_row: `ST_REQ`→`ST_ACT` on grant with `cbr_mode`=0.
- setup_done: `ST_SETUP`→`ST_ACT` after `CSR_CYC` cycles.
- active_done: `ST_ACT`→`ST_PRE` after `RAS_CYC` cycles.
- cycle_done: `ST_PRE`→`ST_IDLE` after `PRE_CYC` cycles.

## Requirements
- R1: While reset is held, `ras_n`=1, `cas_n`=1, `req`=0, `addr_en`=0, `init_done`=0, `err`=0 and `row_addr`=0.
- R2: No strobe moves during the power-up pause. `req` first goes high on the (`PAUSE_CYC`+1)-th rising clock edge after reset is released.
- R3: After the pause, exactly `WAKE_CNT` refresh cycles run before `init_done` rises. `init_done` rises at the end of the last of these cycles.
- R4: While `req` is high and `gnt` is low, `ras_n` and `cas_n` stay high. Neither strobe falls unless `req` was high in the cycle before.
- R5: Each RAS low pulse lasts exactly `RAS_CYC` cycles. At least `PRE_CYC` cycles with RAS high pass before the next fall.
- R6: With `cbr_mode`=1 at grant (CAS-first): `cas_n` is low for exactly `CSR_CYC` cycles before `ras_n` falls and stays low for `CHR_CYC` cycles of the RAS pulse. `addr_en` is 0 throughout.
- R7: With `cbr_mode`=0 at grant (row-addressed): `cas_n` stays high, `addr_en` is 1 while RAS is low, and `row_addr` shows the local row count. The count starts at 0, steps by 1 after each row-addressed cycle, wraps from 1023 to 0, and is left unchanged by CAS-first cycles.
- R8: After `init_done` rises, one refresh is owed every `INTERVAL_CYC` cycles. With the grant held high, the first RAS fall comes `INTERVAL_CYC`+2 rising edges after `init_done` rises, and N intervals yield exactly N refresh cycles.
- R9: Refreshes owed while `gnt` is low are kept, up to `BACKLOG_MAX` of them. All are run back to back once the grant returns, and `err` stays 0.
- R10: When a refresh comes due with `BACKLOG_MAX` already owed, `err` is set and stays set until reset. `init_done` falls, the backlog is discarded, and `WAKE_CNT` wake-up cycles run again before `init_done` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cbr_mode | input | 1 | Refresh style, sampled at grant: 1 CAS-first, 0 row-addressed |
| gnt | input | 1 | Bus grant from the access arbiter |
| req | output | 1 | Bus request, held until the refresh cycle's precharge ends |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| row_addr | output | ROW_W | Local row count for row-addressed refresh |
| addr_en | output | 1 | Address pins driven by this block |
| init_done | output | 1 | Power-up and wake-up sequence complete |
| err | output | 1 | Sticky flag: refresh backlog went past its limit |

## Verification
Some properties are checked on every clock: the ordering of CAS ahead of RAS in CAS-first cycles, CAS staying high in row-addressed cycles, no strobe falling without a request, the error flag staying set, the backlog staying within its limit and the row counter stepping by one. Other properties only show up across the bench's scenarios. These are the exact pause length, the wake-up burst count, the first refresh's position after initialization, the number of refreshes per interval, the backlog being paid back after a stall, and the recovery after an overflow. The row counter wrapping past 1023 is also only visible there.

// File: rtl/refsch_pkg.sv
package refsch_pkg;
    typedef enum logic [2:0] {
        ST_PAUSE = 3'd0,
        ST_IDLE  = 3'd1,
        ST_REQ   = 3'd2,
        ST_SETUP = 3'd3,
        ST_ACT   = 3'd4,
        ST_PRE   = 3'd5
    } refsch_state_e;
endpackage

// File: rtl/refsch_interval.sv
module refsch_interval #(
    parameter int PERIOD = 3120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(PERIOD + 1);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (!en)          cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    assign tick = en && (cnt_q == LAST);

    generate
        if (PERIOD > 1) begin : g_spacing
            a_r8_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/refsch_backlog.sv
module refsch_backlog #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic ovf,
    output logic pending
);
    localparam int BW = $clog2(LIMIT + 1);
    localparam logic [BW-1:0] TOP = BW'(LIMIT);

    logic [BW-1:0] cnt_q;

    assign ovf     = inc && !dec && (cnt_q == TOP);
    assign pending = (cnt_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           cnt_q <= '0;
        else if (ovf)                         cnt_q <= '0;
        else if (inc && !dec)                 cnt_q <= cnt_q + 1'b1;
        else if (dec && !inc && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    a_r9_backlog_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP);
    a_r10_ovf_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (cnt_q == '0));
endmodule

// File: rtl/refsch_rowctr.sv
module refsch_rowctr #(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [ROW_W-1:0] row
);
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   row_q <= '0;
        else if (adv) row_q <= row_q + 1'b1;
    end

    assign row = row_q;

    a_r7_row_step: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (row_q == $past(row_q) + 1'b1));
    a_r7_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(row_q));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import refsch_pkg::*;
#(
    parameter int ROW_W        = 10,
    parameter int PAUSE_CYC    = 40000,
    parameter int WAKE_CNT     = 8,
    parameter int INTERVAL_CYC = 3120,
    parameter int RAS_CYC      = 12,
    parameter int PRE_CYC      = 8,
    parameter int CSR_CYC      = 2,
    parameter int CHR_CYC      = 2,
    parameter int BACKLOG_MAX  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cbr_mode,
    input  logic             gnt,
    output logic             req,
    output logic             ras_n,
    output logic             cas_n,
    output logic [ROW_W-1:0] row_addr,
    output logic             addr_en,
    output logic             init_done,
    output logic             err
);
    localparam int M1   = (PAUSE_CYC > RAS_CYC) ? PAUSE_CYC : RAS_CYC;
    localparam int M2   = (PRE_CYC > CSR_CYC) ? PRE_CYC : CSR_CYC;
    localparam int M3   = (M1 > M2) ? M1 : M2;
    localparam int MAXT = (M3 > CHR_CYC) ? M3 : CHR_CYC;
    localparam int TW   = $clog2(MAXT + 1);
    localparam int WW   = $clog2(WAKE_CNT + 1);
    localparam logic [TW-1:0] PAUSE_LAST = TW'(PAUSE_CYC - 1);
    localparam logic [TW-1:0] RAS_LAST   = TW'(RAS_CYC - 1);
    localparam logic [TW-1:0] PRE_LAST   = TW'(PRE_CYC - 1);
    localparam logic [TW-1:0] CSR_LAST   = TW'(CSR_CYC - 1);
    localparam logic [TW-1:0] CHR_T      = TW'(CHR_CYC);
    localparam logic [WW-1:0] WAKE_N     = WW'(WAKE_CNT);

    refsch_state_e state_q, state_d;
    logic [TW-1:0] tcnt_q;
    logic [WW-1:0] wake_q;
    logic          mode_q, init_q, err_q;
    logic          tick, ovf, owed, done, work;

    assign done = (state_q == ST_PRE) && (tcnt_q == PRE_LAST);
    assign work = (wake_q != '0) || owed;

    refsch_interval #(.PERIOD(INTERVAL_CYC)) u_interval (
        .clk(clk), .rst_n(rst_n), .en(init_q), .tick(tick)
    );

    refsch_backlog #(.LIMIT(BACKLOG_MAX)) u_backlog (
        .clk(clk), .rst_n(rst_n), .inc(tick), .dec(done && (wake_q == '0)),
        .ovf(ovf), .pending(owed)
    );

    refsch_rowctr #(.ROW_W(ROW_W)) u_rowctr (
        .clk(clk), .rst_n(rst_n), .adv(done && !mode_q), .row(row_addr)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PAUSE: if (tcnt_q == PAUSE_LAST) state_d = ST_IDLE;
            ST_IDLE:  if (work)                 state_d = ST_REQ;
            ST_REQ:   if (gnt)                  state_d = cbr_mode ? ST_SETUP : ST_ACT;
            ST_SETUP: if (tcnt_q == CSR_LAST)   state_d = ST_ACT;
            ST_ACT:   if (tcnt_q == RAS_LAST)   state_d = ST_PRE;
            ST_PRE:   if (tcnt_q == PRE_LAST)   state_d = ST_IDLE;
            default:                            state_d = ST_PAUSE;
        endcase
    end

    // State register and sequencing counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PAUSE;
            tcnt_q  <= '0;
            wake_q  <= '0;
            mode_q  <= 1'b0;
            init_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q)
                tcnt_q <= '0;
            else if (state_q != ST_IDLE && state_q != ST_REQ)
                tcnt_q <= tcnt_q + 1'b1;
            if (state_q == ST_REQ && gnt)
                mode_q <= cbr_mode;
            if (ovf) begin
                wake_q <= WAKE_N;
                init_q <= 1'b0;
                err_q  <= 1'b1;
            end else if (state_q == ST_PAUSE && state_d == ST_IDLE) begin
                wake_q <= WAKE_N;
            end else if (done && wake_q != '0) begin
                wake_q <= wake_q - 1'b1;
                if (wake_q == WW'(1)) init_q <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        req     = (state_q == ST_REQ) || (state_q == ST_SETUP) ||
                  (state_q == ST_ACT) || (state_q == ST_PRE);
        ras_n   = (state_q != ST_ACT);
        cas_n   = !((state_q == ST_SETUP) ||
                    (state_q == ST_ACT && mode_q && tcnt_q < CHR_T));
        addr_en = (state_q == ST_ACT) && !mode_q;
    end

    assign init_done = init_q;
    assign err       = err_q;

    a_r6_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && mode_q) |-> (!cas_n && !$past(cas_n)));
    a_r7_row_mode_cas_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && !mode_q) |-> cas_n);
    a_r4_strobe_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) || $fell(cas_n)) |-> $past(req));
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err) |-> err);
    a_r6_no_addr_cbr: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && !ras_n) |-> !addr_en);
endmodule

// File: tb/dram_refresh_sched_bench.sv
`timescale 1ns/1ps
module dram_refresh_sched_bench;
    localparam int P_PAUSE = 50;
    localparam int P_WAKE  = 8;
    localparam int P_INT   = 40;
    localparam int P_RAS   = 4;
    localparam int P_PRE   = 3;
    localparam int P_CSR   = 2;
    localparam int P_CHR   = 2;
    localparam int P_LIM   = 2;
    localparam int P_ROWW  = 10;

    logic clk = 1'b0, rst_n = 1'b0, cbr_mode = 1'b0, gnt = 1'b0;
    logic req, ras_n, cas_n, addr_en, init_done, err;
    logic [P_ROWW-1:0] row_addr;

    dram_refresh_sched #(
        .ROW_W(P_ROWW), .PAUSE_CYC(P_PAUSE), .WAKE_CNT(P_WAKE),
        .INTERVAL_CYC(P_INT), .RAS_CYC(P_RAS), .PRE_CYC(P_PRE),
        .CSR_CYC(P_CSR), .CHR_CYC(P_CHR), .BACKLOG_MAX(P_LIM)
    ) u_dram_refresh_sched (
        .clk(clk), .rst_n(rst_n), .cbr_mode(cbr_mode), .gnt(gnt),
        .req(req), .ras_n(ras_n), .cas_n(cas_n), .row_addr(row_addr),
        .addr_en(addr_en), .init_done(init_done), .err(err)
    );

    always #2.5 clk = ~clk;

    int ecnt = 0;
    always @(posedge clk) ecnt <= ecnt + 1;

    int n_chk = 0, n_bad = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic int next_row(input int r);
        return (r + 1) % (1 << P_ROWW);
    endfunction
    function automatic int first_req_edge();
        return P_PAUSE + 1;
    endfunction
    function automatic int first_refresh_edge();
        return P_INT + 2;
    endfunction

    // Pulse monitor, sampled on the falling clock edge
    bit   mon_on = 1'b0, wrap_arm = 1'b0, wrap_seen = 1'b0;
    logic prev_ras = 1'b1, prev_cas = 1'b1, prev_init = 1'b0;
    int   ras_low_run = 0, ras_high_run = 0, cas_low_run = 0;
    int   pulses = 0, exp_row = 0, e0 = 0;

    always @(negedge clk) begin
        if (mon_on) begin
            if (prev_ras && !ras_n) begin
                pulses++;
                chk(ras_high_run >= P_PRE, "R5 precharge before RAS", ras_high_run, P_PRE);
                if (cbr_mode) begin
                    chk(!cas_n && cas_low_run == P_CSR, "R6 CAS setup", cas_low_run, P_CSR);
                    chk(!addr_en, "R6 address released", int'(addr_en), 0);
                end else begin
                    chk(cas_n === 1'b1, "R7 CAS high at RAS fall", int'(cas_n), 1);
                    chk(addr_en === 1'b1, "R7 address driven", int'(addr_en), 1);
                    chk(int'(row_addr) == exp_row, "R7 row address", int'(row_addr), exp_row);
                    if (wrap_arm && exp_row == 0) wrap_seen = 1'b1;
                    if (exp_row == (1 << P_ROWW) - 1) wrap_arm = 1'b1;
                    exp_row = next_row(exp_row);
                end
            end
            if (!prev_ras && ras_n)
                chk(ras_low_run == P_RAS, "R5 RAS width", ras_low_run, P_RAS);
            if (!ras_n && !prev_ras && !prev_cas && cas_n)
                chk(cbr_mode && ras_low_run == P_CHR, "R6 CAS hold", ras_low_run, P_CHR);
            if (!ras_n && !cbr_mode)
                chk(cas_n === 1'b1, "R7 CAS stays high", int'(cas_n), 1);
            if (!prev_init && init_done) e0 = ecnt;
            ras_low_run  = ras_n ? 0 : ras_low_run + 1;
            ras_high_run = ras_n ? ras_high_run + 1 : 0;
            cas_low_run  = cas_n ? 0 : cas_low_run + 1;
            prev_ras  = ras_n;
            prev_cas  = cas_n;
            prev_init = init_done;
        end
    end

    task automatic tick_n();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_idle_phase();
        do tick_n(); while (!((((ecnt - e0) % P_INT) == P_INT / 2) && !req));
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        summary();
        $finish;
    end

    initial begin
        int r0, t0, p0, row0, loops;
        void'($urandom(32'd7321));
        repeat (4) tick_n();
        // R1 reset values
        chk(ras_n && cas_n, "R1 strobes idle", int'({ras_n, cas_n}), 3);
        chk(!req && !addr_en, "R1 req/addr_en low", int'({req, addr_en}), 0);
        chk(!init_done && !err, "R1 init/err low", int'({init_done, err}), 0);
        chk(row_addr == '0, "R1 row zero", int'(row_addr), 0);

        rst_n = 1'b1;
        r0 = ecnt;
        mon_on = 1'b1;
        while (!req) tick_n();
        chk(ecnt - r0 == first_req_edge(), "R2 pause length", ecnt - r0, first_req_edge());
        chk(pulses == 0, "R2 no strobe during pause", pulses, 0);

        // R4 request waits for grant
        repeat (10) begin
            tick_n();
            chk(req && ras_n && cas_n, "R4 hold without grant", int'({req, ras_n, cas_n}), 7);
        end
        gnt = 1'b1;

        // R3 wake-up burst
        while (!init_done) tick_n();
        chk(pulses == P_WAKE, "R3 wake-up count", pulses, P_WAKE);

        // R8 first periodic refresh
        t0 = ecnt;
        p0 = pulses;
        while (pulses == p0) tick_n();
        chk(ecnt - t0 == first_refresh_edge(), "R8 first refresh", ecnt - t0, first_refresh_edge());

        // R6 CAS-first refresh run; row count must not move
        wait_idle_phase();
        cbr_mode = 1'b1;
        p0 = pulses;
        row0 = int'(row_addr);
        repeat (5 * P_INT) tick_n();
        chk(pulses - p0 == 5, "R8 refresh per interval (CBR)", pulses - p0, 5);
        chk(int'(row_addr) == row0, "R7 row untouched by CBR", int'(row_addr), row0);
        wait_idle_phase();
        cbr_mode = 1'b0;

        // R9 backlog paid back after stall
        wait_idle_phase();
        gnt = 1'b0;
        repeat (2 * P_INT) begin
            tick_n();
            chk(ras_n && cas_n, "R4 no strobe while stalled", int'({ras_n, cas_n}), 3);
        end
        gnt = 1'b1;
        p0 = pulses;
        repeat (18) tick_n();
        chk(pulses - p0 == 2, "R9 backlog served", pulses - p0, 2);
        chk(!err, "R9 no error within limit", int'(err), 0);

        // Random grant and mode mix
        repeat (3000) begin
            tick_n();
            gnt = ($urandom_range(3) != 0);
            if (!req && $urandom_range(7) == 0) cbr_mode = ~cbr_mode;
        end
        gnt = 1'b1;
        while (req) tick_n();
        cbr_mode = 1'b0;
        chk(!err, "R9 no error under random grant", int'(err), 0);
        repeat (P_INT) tick_n();

        // R10 overflow and re-wake
        wait_idle_phase();
        gnt = 1'b0;
        repeat (3 * P_INT) tick_n();
        chk(err === 1'b1, "R10 error set", int'(err), 1);
        chk(init_done === 1'b0, "R10 init dropped", int'(init_done), 0);
        gnt = 1'b1;
        p0 = pulses;
        while (!init_done) tick_n();
        chk(pulses - p0 == P_WAKE, "R10 re-wake count", pulses - p0, P_WAKE);
        repeat (5) tick_n();
        chk(err === 1'b1, "R10 error sticky", int'(err), 1);

        // R8 long-run rate
        wait_idle_phase();
        p0 = pulses;
        repeat (20 * P_INT) tick_n();
        chk(pulses - p0 == 20, "R8 refresh per interval", pulses - p0, 20);

        // R7 wrap of row counter
        loops = 0;
        while (!wrap_seen && loops < 1100 * P_INT) begin
            tick_n();
            loops++;
        end
        chk(wrap_seen, "R7 row wrap 1023 to 0", int'(wrap_seen), 1);

        summary();
        $finish;
    end
endmodule